// File: doc/BRIEF.md
# SDRAM Command Decoder with Clock-Enable Control

This block is the device-side command front end of a two-bank synchronous DRAM with a 16-bit data word. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank select and an 11-bit address bus. From these it produces one-cycle decoded command pulses, the latched bank, row and column, and the open or idle state of each bank.

Clock enable controls the block's internal clock. When clock enable is sampled low, the command on that same edge is still taken. From the next edge on, all registered state and outputs are frozen. If both banks are idle after that edge, the block reports power-down. Otherwise it reports clock suspend. When clock enable is sampled high again, the block wakes on that same edge and accepts the command presented with it.

Top module: `sdram_cmd_frontend`

## Requirements
- R1: While rst_n is low, every strobe, flag, latched field and bank-open bit is 0.
- R2: With cs_n low, the command bits {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode set. The matching strobe is high for exactly the cycle after the accepting edge, and at most one strobe is high at a time.
- R3: A sample with cs_n high, or with cs_n low and {ras_n,cas_n,we_n}=111, raises no strobe and changes no bank state and no latched field.
- R4: An activate to an idle bank sets that bank's open bit (open_o[ba]) and latches bank_o=ba and row_o=addr.
- R5: A read or write to an open bank latches bank_o=ba and col_o=addr[7:0], and leaves row_o unchanged.
- R6: A precharge latches bank_o=ba. With addr[10]=1 it clears both open bits. With addr[10]=0 it clears only open_o[ba].
- R7: A read or write to an idle bank, or an activate to an open bank, sets illegal_o for one cycle. It raises no strobe and changes neither open_o nor any latched field.
- R8: A mode set latches bank_o=ba. An auto-refresh leaves bank_o, row_o and col_o unchanged.
- R9: On an edge where cke is sampled low after having been high, the command is still accepted. If a bank is open afterwards, suspend_o goes to 1. On each later edge where cke is still low, inputs are ignored and every output holds its value.
- R10: On an edge where cke is sampled low after having been high and both banks are idle afterwards, pdown_o goes to 1. It holds while cke stays low. suspend_o and pdown_o are never both 1.
- R11: On the first edge where cke is sampled high again, the command on that edge is accepted, and suspend_o and pdown_o return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | 1 | Bank select |
| addr | input | 11 | Multiplexed row/column address; bit 10 selects all-bank precharge |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| ref_o | output | 1 | Auto-refresh accepted |
| mrs_o | output | 1 | Mode set accepted |
| illegal_o | output | 1 | Last command conflicted with bank state |
| bank_o | output | 1 | Latched bank |
| row_o | output | 11 | Latched row address |
| col_o | output | 8 | Latched column address |
| open_o | output | 2 | Per-bank open flags |
| suspend_o | output | 1 | Clock suspended with a bank open |
| pdown_o | output | 1 | Power-down with both banks idle |

## Verification
The bench targets the edge where cke first drops. A design that freezes one edge too early would lose the write issued on that edge. It also targets the wake edge. A design that needs an extra cycle to wake would drop the activate presented with cke high. Deselects that carry activate bits are driven to catch a decoder that ignores chip select. Conflicting commands are driven to catch a design that opens or updates a bank anyway. All-bank precharge is driven against single-bank precharge to catch a misread of address bit 10. Low-power entry is tried with banks open and with banks idle, so that a design that chooses between suspend and power-down using the state from before the entering command is caught.

// File: rtl/sdram_cmd_frontend.sv
module sdram_cmd_frontend #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             ba,
  input  logic [ROW_W-1:0] addr,
  output logic             act_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             pre_o,
  output logic             ref_o,
  output logic             mrs_o,
  output logic             illegal_o,
  output logic             bank_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [1:0]       open_o,
  output logic             suspend_o,
  output logic             pdown_o
);

  logic       cke_q;
  logic [2:0] cmd;
  logic       act_c, rd_c, wr_c, pre_c, ref_c, mrs_c;
  logic       hit, ill, go;
  logic [1:0] open_nx;

  assign cmd   = {ras_n, cas_n, we_n};
  assign act_c = !cs_n && cmd == 3'b011;
  assign rd_c  = !cs_n && cmd == 3'b101;
  assign wr_c  = !cs_n && cmd == 3'b100;
  assign pre_c = !cs_n && cmd == 3'b010;
  assign ref_c = !cs_n && cmd == 3'b001;
  assign mrs_c = !cs_n && cmd == 3'b000;
  assign hit   = open_o[ba];
  assign ill   = ((rd_c || wr_c) && !hit) || (act_c && hit);
  assign go    = cke || cke_q;

  always_comb begin
    open_nx = open_o;
    if (pre_c) begin
      if (addr[AP_BIT]) open_nx = '0;
      else              open_nx[ba] = 1'b0;
    end
    if (act_c && !hit) open_nx[ba] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      act_o     <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      pre_o     <= 1'b0;
      ref_o     <= 1'b0;
      mrs_o     <= 1'b0;
      illegal_o <= 1'b0;
      bank_o    <= 1'b0;
      row_o     <= '0;
      col_o     <= '0;
      open_o    <= '0;
      suspend_o <= 1'b0;
      pdown_o   <= 1'b0;
    end else begin
      cke_q <= cke;
      if (go) begin
        act_o     <= act_c && !ill;
        rd_o      <= rd_c && !ill;
        wr_o      <= wr_c && !ill;
        pre_o     <= pre_c;
        ref_o     <= ref_c;
        mrs_o     <= mrs_c;
        illegal_o <= ill;
        open_o    <= open_nx;
        if (!ill && (act_c || rd_c || wr_c || pre_c || mrs_c)) bank_o <= ba;
        if (act_c && !ill) row_o <= addr;
        if ((rd_c || wr_c) && !ill) col_o <= addr[COL_W-1:0];
      end
      if (cke) begin
        suspend_o <= 1'b0;
        pdown_o   <= 1'b0;
      end else if (cke_q) begin
        suspend_o <= open_nx != '0;
        pdown_o   <= open_nx == '0;
      end
    end
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o}));

  // R7
  illegal_keeps_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(open_o));

  // R9
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cke_q) |=> ($stable(open_o) && $stable(row_o) && $stable(col_o)
                          && $stable(bank_o) && $stable(suspend_o) && $stable(pdown_o)));

  // R10
  lowpower_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(suspend_o && pdown_o));

  // R10
  pdown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_o |-> open_o == 2'b00);

  // R11
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> (!suspend_o && !pdown_o));

endmodule

// File: tb/tb_sdram_cmd_frontend.sv
module tb_sdram_cmd_frontend;
  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, ba = 0;
  logic [10:0] addr = '0;
  logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o, bank_o, suspend_o, pdown_o;
  logic [10:0] row_o;
  logic [7:0] col_o;
  logic [1:0] open_o;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  sdram_cmd_frontend dut (.*);

  logic [5:0] m_str;
  logic m_ill, m_bank, m_su, m_pd, m_ckeq;
  logic [10:0] m_row;
  logic [7:0] m_col;
  logic [1:0] m_open;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_str = '0; m_ill = 0; m_bank = 0; m_su = 0; m_pd = 0; m_ckeq = 1;
    m_row = '0; m_col = '0; m_open = '0;
  endtask

  function automatic logic [1:0] next_open(logic [1:0] o, logic [2:0] c, logic b, logic a10, logic sel);
    logic [1:0] n = o;
    if (sel && c == C_PRE) begin
      if (a10) n = 2'b00; else n[b] = 1'b0;
    end
    if (sel && c == C_ACT && !o[b]) n[b] = 1'b1;
    return n;
  endfunction

  task automatic model_step(logic k, logic cs, logic [2:0] c, logic b, logic [10:0] a);
    logic sel = !cs;
    logic hit = m_open[b];
    logic il = sel && (((c == C_RD || c == C_WR) && !hit) || (c == C_ACT && hit));
    logic [1:0] nx = next_open(m_open, c, b, a[10], sel);
    if (k || m_ckeq) begin
      m_str = {sel && c == C_ACT && !il, sel && c == C_RD && !il, sel && c == C_WR && !il,
               sel && c == C_PRE, sel && c == C_REF, sel && c == C_MRS};
      m_ill = il;
      if (sel && !il && c != C_REF && c != C_NOP) m_bank = b;
      if (sel && c == C_ACT && !il) m_row = a;
      if (sel && (c == C_RD || c == C_WR) && !il) m_col = a[7:0];
      m_open = nx;
    end
    if (k) begin m_su = 0; m_pd = 0; end
    else if (m_ckeq) begin m_su = nx != 0; m_pd = nx == 0; end
    m_ckeq = k;
  endtask

  task automatic compare();
    chk("R2 strobes", {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o}, m_str);
    chk("R7 illegal", illegal_o, m_ill);
    chk("R4 row", row_o, m_row);
    chk("R5 col", col_o, m_col);
    chk("R8 bank", bank_o, m_bank);
    chk("R6 open", open_o, m_open);
    chk("R9 suspend", suspend_o, m_su);
    chk("R10 pdown", pdown_o, m_pd);
  endtask

  task automatic issue(logic k, logic cs, logic [2:0] c, logic b, logic [10:0] a);
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    #1;
    model_step(k, cs, c, b, a);
    compare();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    #9;
    chk("R1 reset outputs", {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o, bank_o,
        suspend_o, pdown_o, open_o}, 0);
    chk("R1 reset fields", {row_o, col_o}, 0);
    @(negedge clk);
    rst_n = 1;

    issue(1, 0, C_ACT, 0, 11'h155);
    chk("R4 act strobe", act_o, 1);
    chk("R4 row latched", row_o, 11'h155);
    issue(1, 1, C_ACT, 1, 11'h0AA);
    chk("R3 deselect no strobe", act_o, 0);
    chk("R3 deselect banks", open_o, 2'b01);
    issue(1, 0, C_NOP, 1, 11'h7FF);
    chk("R3 nop row held", row_o, 11'h155);
    issue(1, 0, C_RD, 0, 11'h3A7);
    chk("R5 col latched", col_o, 8'hA7);
    issue(1, 0, C_RD, 1, 11'h011);
    chk("R7 read idle bank", {illegal_o, rd_o, open_o}, {1'b1, 1'b0, 2'b01});
    chk("R7 col unchanged", col_o, 8'hA7);
    issue(1, 0, C_ACT, 0, 11'h222);
    chk("R7 act open bank", {illegal_o, row_o}, {1'b1, 11'h155});
    issue(1, 0, C_MRS, 1, 11'h033);
    chk("R8 mode set bank", {mrs_o, bank_o}, 2'b11);
    issue(1, 0, C_REF, 0, 11'h044);
    chk("R8 refresh keeps bank", {ref_o, bank_o}, 2'b11);

    issue(0, 0, C_WR, 0, 11'h012);
    chk("R9 entry write accepted", {wr_o, col_o}, {1'b1, 8'h12});
    chk("R9 suspend set", {suspend_o, pdown_o}, 2'b10);
    issue(0, 0, C_PRE, 0, 11'h400);
    chk("R9 frozen", {wr_o, pre_o, open_o}, {1'b1, 1'b0, 2'b01});
    issue(1, 0, C_PRE, 0, 11'h000);
    chk("R11 wake accepts", {pre_o, open_o, suspend_o}, {1'b1, 2'b00, 1'b0});
    issue(0, 0, C_NOP, 0, 11'h000);
    chk("R10 pdown entry", {pdown_o, suspend_o}, 2'b10);
    issue(0, 0, C_ACT, 1, 11'h0F0);
    chk("R10 pdown holds", {pdown_o, open_o}, {1'b1, 2'b00});
    issue(1, 0, C_ACT, 1, 11'h0F0);
    chk("R11 wake act", {act_o, open_o, pdown_o}, {1'b1, 2'b10, 1'b0});
    issue(1, 0, C_ACT, 0, 11'h00F);
    issue(1, 0, C_PRE, 1, 11'h000);
    chk("R6 single bank", open_o, 2'b01);
    issue(1, 0, C_ACT, 1, 11'h00F);
    issue(1, 0, C_PRE, 0, 11'h400);
    chk("R6 all banks", {open_o, bank_o}, 3'b000);

    for (int i = 0; i < 600; i++) begin
      logic k = ($urandom % 100) < 80;
      logic cs = ($urandom % 100) < 15;
      logic [2:0] c = 3'($urandom);
      issue(k, cs, c, 1'($urandom), 11'($urandom));
    end
    finish_run();
  end
endmodule